// File: doc/BRIEF.md
# Serial Receiver with Address Wake-Up Filter

This block receives asynchronous serial frames on a single line. The line is sampled on a 16x oversampling tick supplied from outside, and each frame is assembled into a byte-wide data register. Four sticky status flags report the result: data available, bad stop bit, bad parity and data lost to overrun. A fifth flag holds the last received address marker bit. Two interrupt requests are derived from these flags and their enables. Software clears each flag with a one-cycle strobe.

In address-marker format, each frame carries a ninth bit that tells address frames (marker 1) apart from data frames (marker 0). A node on a shared line can arm the wake-up filter. While the filter is armed, every data frame is dropped without any side effect. The first address frame is delivered normally and disarms the filter in hardware, so the node handles the address and then decides whether to listen to the data that follows. In plain format, the ninth bit can instead be an even parity bit, or it can be left out.

Top module: `uart_mp_rx`

## Requirements
- R1: While rx_en_i is 0 no frame is received. Lowering rx_en_i leaves rx_full_o, fer_o, per_o and ovr_o unchanged.
- R2: A frame is a 0 start bit, then 8 data bits LSB first, then an optional ninth bit, then a stop bit, each 16 ticks long. The ninth bit is present when mp_fmt_i=1 (marker) or par_en_i=1 (parity). A complete frame loads rx_data_o and sets rx_full_o.
- R3: A start bit that reads 1 again at its midpoint (8 ticks after the falling edge) is rejected, and no frame results.
- R4: A stop bit sampled as 0 sets fer_o. The data is still loaded.
- R5: With par_en_i=1 and mp_fmt_i=0, per_o is set when the 8 data bits plus the parity bit hold an odd number of ones (even parity).
- R6: A frame that completes while rx_full_o is 1 sets ovr_o. It leaves rx_data_o, fer_o and per_o unchanged.
- R7: A 1 on clr_full_i, clr_fer_i, clr_per_i, clr_ovr_i or clr_mpb_i clears the matching flag. wake_set_i arms the filter and wake_clr_i disarms it.
- R8: While wake_armed_o=1 and mp_fmt_i=1, a frame with marker 0 is discarded. rx_data_o and all flags are left unchanged, and the filter stays armed.
- R9: A marker-1 frame in marker format sets mpb_o and is delivered as in R2. If the filter is armed, it also clears wake_armed_o. In marker format, mpb_o takes the marker bit of each frame that is not discarded.
- R10: With mp_fmt_i=0 the wake-up filter has no effect. Frames are delivered and wake_armed_o keeps its value.
- R11: rx_irq_o is rx_full_o AND ie_rx_i. err_irq_o is (fer_o OR per_o OR ovr_o) AND ie_err_i.
- R12: After reset, rx_data_o is 0, all flags are 0 and wake_armed_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | 16x oversampling tick |
| rx_en_i | input | 1 | Receiver enable |
| mp_fmt_i | input | 1 | Ninth bit is an address marker |
| par_en_i | input | 1 | Ninth bit is even parity (when mp_fmt_i=0) |
| wake_set_i | input | 1 | Arm wake-up filter |
| wake_clr_i | input | 1 | Disarm wake-up filter |
| ie_rx_i | input | 1 | Receive interrupt enable |
| ie_err_i | input | 1 | Error interrupt enable |
| clr_full_i | input | 1 | Clear rx_full_o |
| clr_fer_i | input | 1 | Clear fer_o |
| clr_per_i | input | 1 | Clear per_o |
| clr_ovr_i | input | 1 | Clear ovr_o |
| clr_mpb_i | input | 1 | Clear mpb_o |
| rx_data_o | output | 8 | Received data register |
| rx_full_o | output | 1 | Data available |
| fer_o | output | 1 | Framing error |
| per_o | output | 1 | Parity error |
| ovr_o | output | 1 | Overrun |
| mpb_o | output | 1 | Received marker bit |
| wake_armed_o | output | 1 | Wake-up filter armed |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The line passes through a two-stage synchronizer. The stop bit is sampled on the eighth tick after its nominal midpoint count starts, and the data register and flags change one clock after that sample. The whole path settles within about half a bit time of the stop-bit boundary. The bench therefore holds the stop bit for its full 32 clocks, then idles the line for two more bit times before sampling any output on a falling clock edge. Clear strobes take effect on the next rising edge and are checked one clock later. The interrupt outputs are combinational from the flags and enables, and they are checked in the same sample as the flags.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_BIT9,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              b9;
    logic              stop;
    logic              fmt_mp;
    logic              fmt_par;
  } rx_frame_t;
endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_mp_rx_shift.sv
module uart_mp_rx_shift
  import uart_mp_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic      mp_fmt_i,
  input  logic      par_en_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              line_q, b9_q, stop_q, fmt_mp_q, fmt_par_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      line_q    <= 1'b1;
      b9_q      <= 1'b0;
      stop_q    <= 1'b1;
      fmt_mp_q  <= 1'b0;
      fmt_par_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) line_q <= rxd_i;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            // falling edge seen between two ticks
            if (line_q && !rxd_i) begin
              state_q   <= ST_START;
              cnt_q     <= '0;
              b9_q      <= 1'b0;
              fmt_mp_q  <= mp_fmt_i;
              fmt_par_q <= par_en_i & ~mp_fmt_i;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              state_q <= rxd_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST)
                state_q <= (fmt_mp_q || fmt_par_q) ? ST_BIT9 : ST_STOP;
              else
                idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BIT9: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              b9_q    <= rxd_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              stop_q  <= rxd_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = '{data: sh_q, b9: b9_q, stop: stop_q,
                     fmt_mp: fmt_mp_q, fmt_par: fmt_par_q};
endmodule

// File: rtl/uart_mp_rx_flags.sv
module uart_mp_rx_flags
  import uart_mp_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              wake_set_i,
  input  logic              wake_clr_i,
  input  logic              ie_rx_i,
  input  logic              ie_err_i,
  input  logic              clr_full_i,
  input  logic              clr_fer_i,
  input  logic              clr_per_i,
  input  logic              clr_ovr_i,
  input  logic              clr_mpb_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              fer_o,
  output logic              per_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              armed_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, fer_q, per_q, ovr_q, mpb_q, armed_q;
  logic discard, accept, load, lost, wake, par_bad;

  always_comb begin
    discard = done_i & frame_i.fmt_mp & armed_q & ~frame_i.b9;
    accept  = done_i & ~discard;
    load    = accept & ~full_q;
    lost    = accept & full_q;
    wake    = accept & frame_i.fmt_mp & frame_i.b9 & armed_q;
    par_bad = frame_i.fmt_par & (^{frame_i.data, frame_i.b9});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      fer_q   <= 1'b0;
      per_q   <= 1'b0;
      ovr_q   <= 1'b0;
      mpb_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (load) data_q <= frame_i.data;
      full_q <= load | (full_q & ~clr_full_i);
      fer_q  <= (load & ~frame_i.stop) | (fer_q & ~clr_fer_i);
      per_q  <= (load & par_bad) | (per_q & ~clr_per_i);
      ovr_q  <= lost | (ovr_q & ~clr_ovr_i);
      if (accept && frame_i.fmt_mp) mpb_q <= frame_i.b9;
      else if (clr_mpb_i)           mpb_q <= 1'b0;
      if (wake_set_i)               armed_q <= 1'b1;
      else if (wake_clr_i || wake)  armed_q <= 1'b0;
    end
  end

  assign data_o    = data_q;
  assign full_o    = full_q;
  assign fer_o     = fer_q;
  assign per_o     = per_q;
  assign ovr_o     = ovr_q;
  assign mpb_o     = mpb_q;
  assign armed_o   = armed_q;
  assign rx_irq_o  = full_q & ie_rx_i;
  assign err_irq_o = (fer_q | per_q | ovr_q) & ie_err_i;
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              mp_fmt_i,
  input  logic              par_en_i,
  input  logic              wake_set_i,
  input  logic              wake_clr_i,
  input  logic              ie_rx_i,
  input  logic              ie_err_i,
  input  logic              clr_full_i,
  input  logic              clr_fer_i,
  input  logic              clr_per_i,
  input  logic              clr_ovr_i,
  input  logic              clr_mpb_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              fer_o,
  output logic              per_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              wake_armed_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic      rxd_s;
  logic      frm_done;
  rx_frame_t frm;

  uart_mp_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_mp_rx_shift #(.OSR(OSR)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i),
    .tick_i  (tick_i),
    .rxd_i   (rxd_s),
    .mp_fmt_i(mp_fmt_i),
    .par_en_i(par_en_i),
    .done_o  (frm_done),
    .frame_o (frm)
  );

  uart_mp_rx_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (frm_done),
    .frame_i   (frm),
    .wake_set_i(wake_set_i),
    .wake_clr_i(wake_clr_i),
    .ie_rx_i   (ie_rx_i),
    .ie_err_i  (ie_err_i),
    .clr_full_i(clr_full_i),
    .clr_fer_i (clr_fer_i),
    .clr_per_i (clr_per_i),
    .clr_ovr_i (clr_ovr_i),
    .clr_mpb_i (clr_mpb_i),
    .data_o    (rx_data_o),
    .full_o    (rx_full_o),
    .fer_o     (fer_o),
    .per_o     (per_o),
    .ovr_o     (ovr_o),
    .mpb_o     (mpb_o),
    .armed_o   (wake_armed_o),
    .rx_irq_o  (rx_irq_o),
    .err_irq_o (err_irq_o)
  );
endmodule

// File: rtl/uart_mp_rx_chk.sv
module uart_mp_rx_chk
  import uart_mp_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              wake_set_i,
  input logic              wake_clr_i,
  input logic              ie_rx_i,
  input logic              ie_err_i,
  input logic              frm_done,
  input rx_frame_t         frm,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              fer_o,
  input logic              ovr_o,
  input logic              mpb_o,
  input logic              wake_armed_o,
  input logic              rx_irq_o,
  input logic              err_irq_o
);
  logic drop;
  assign drop = frm_done && frm.fmt_mp && wake_armed_o && !frm.b9;

  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !frm_done);

  a_r2_full_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(frm_done));

  a_r6_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && rx_full_o && !drop) |=> (ovr_o && $stable(rx_data_o)));

  a_r8_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ($stable(rx_data_o) && !$rose(rx_full_o) && !$rose(fer_o) && !$rose(ovr_o)));

  a_r9_wake_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && frm.fmt_mp && frm.b9 && wake_armed_o && !wake_set_i) |=> (!wake_armed_o && mpb_o));

  a_r10_plain_keeps_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && !frm.fmt_mp && wake_armed_o && !wake_clr_i) |=> wake_armed_o);

  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o |-> ie_rx_i) and (err_irq_o |-> ie_err_i));
endmodule

bind uart_mp_rx uart_mp_rx_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .wake_set_i  (wake_set_i),
  .wake_clr_i  (wake_clr_i),
  .ie_rx_i     (ie_rx_i),
  .ie_err_i    (ie_err_i),
  .frm_done    (frm_done),
  .frm         (frm),
  .rx_data_o   (rx_data_o),
  .rx_full_o   (rx_full_o),
  .fer_o       (fer_o),
  .ovr_o       (ovr_o),
  .mpb_o       (mpb_o),
  .wake_armed_o(wake_armed_o),
  .rx_irq_o    (rx_irq_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/test_uart_mp_rx.sv
module test_uart_mp_rx;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, tdiv = 1'b0;
  logic rx_en = 0, mp_fmt = 0, par_en = 0, wake_set = 0, wake_clr = 0;
  logic ie_rx = 0, ie_err = 0;
  logic clr_full = 0, clr_fer = 0, clr_per = 0, clr_ovr = 0, clr_mpb = 0;
  logic [7:0] rx_data;
  logic rx_full, fer, per, ovr, mpb, armed, rx_irq, err_irq;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_data = 0;
  logic m_full = 0, m_fer = 0, m_per = 0, m_ovr = 0, m_mpb = 0, m_armed = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin tdiv <= 1'b0; tick <= 1'b0; end
    else begin tdiv <= ~tdiv; tick <= tdiv; end
  end

  uart_mp_rx i_uart_mp_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick), .rx_en_i(rx_en),
    .mp_fmt_i(mp_fmt), .par_en_i(par_en), .wake_set_i(wake_set), .wake_clr_i(wake_clr),
    .ie_rx_i(ie_rx), .ie_err_i(ie_err), .clr_full_i(clr_full), .clr_fer_i(clr_fer),
    .clr_per_i(clr_per), .clr_ovr_i(clr_ovr), .clr_mpb_i(clr_mpb),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .fer_o(fer), .per_o(per), .ovr_o(ovr),
    .mpb_o(mpb), .wake_armed_o(armed), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "data",    rx_data, m_data);
    chk(req, "full",    {7'd0, rx_full}, {7'd0, m_full});
    chk(req, "fer",     {7'd0, fer},     {7'd0, m_fer});
    chk(req, "per",     {7'd0, per},     {7'd0, m_per});
    chk(req, "ovr",     {7'd0, ovr},     {7'd0, m_ovr});
    chk(req, "mpb",     {7'd0, mpb},     {7'd0, m_mpb});
    chk(req, "armed",   {7'd0, armed},   {7'd0, m_armed});
    chk(req, "rx_irq",  {7'd0, rx_irq},  {7'd0, m_full & ie_rx});
    chk(req, "err_irq", {7'd0, err_irq}, {7'd0, (m_fer | m_per | m_ovr) & ie_err});
  endtask

  // expected effect of one completed frame
  task automatic model_frame(logic [7:0] d, logic b9, logic stop);
    logic fm, fp;
    fm = mp_fmt;
    fp = par_en & ~mp_fmt;
    if (!rx_en) return;
    if (fm && m_armed && !b9) return;
    if (m_full) m_ovr = 1'b1;
    else begin
      m_data = d;
      m_full = 1'b1;
      if (!stop) m_fer = 1'b1;
      if (fp && (^{d, b9})) m_per = 1'b1;
    end
    if (fm) begin
      m_mpb = b9;
      if (b9) m_armed = 1'b0;
    end
  endtask

  task automatic send(logic [7:0] d, logic b9, logic stop);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (mp_fmt || par_en) begin
      rxd = b9;
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    model_frame(d, b9, stop);
  endtask

  task automatic clear(logic f, logic fe, logic pe, logic ov, logic mb);
    clr_full = f; clr_fer = fe; clr_per = pe; clr_ovr = ov; clr_mpb = mb;
    @(negedge clk);
    clr_full = 0; clr_fer = 0; clr_per = 0; clr_ovr = 0; clr_mpb = 0;
    @(negedge clk);
    if (f) m_full = 0;
    if (fe) m_fer = 0;
    if (pe) m_per = 0;
    if (ov) m_ovr = 0;
    if (mb) m_mpb = 0;
  endtask

  task automatic arm(logic on);
    if (on) wake_set = 1'b1; else wake_clr = 1'b1;
    @(negedge clk);
    wake_set = 1'b0; wake_clr = 1'b0;
    @(negedge clk);
    m_armed = on;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check_all("R12");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12");
    ie_rx = 1; ie_err = 1; rx_en = 1;

    send(8'hA5, 1'b0, 1'b1);  check_all("R2");
    send(8'h3C, 1'b0, 1'b1);  check_all("R6");
    clear(1, 0, 0, 1, 0);     check_all("R7");
    send(8'h81, 1'b0, 1'b0);  check_all("R4");
    clear(1, 1, 0, 0, 0);     check_all("R7");

    par_en = 1;
    send(8'h07, 1'b1, 1'b1);  check_all("R5");  // 4 ones: good
    clear(1, 0, 0, 0, 0);
    send(8'h07, 1'b0, 1'b1);  check_all("R5");  // 3 ones: bad
    clear(1, 0, 1, 0, 0);
    par_en = 0;

    mp_fmt = 1;
    arm(1);                   check_all("R7");
    send(8'h55, 1'b0, 1'b0);  check_all("R8");
    send(8'h66, 1'b1, 1'b1);  check_all("R9");
    clear(1, 0, 0, 0, 1);     check_all("R7");

    mp_fmt = 0;
    arm(1);
    send(8'h12, 1'b0, 1'b1);  check_all("R10");
    clear(1, 0, 0, 0, 0);
    arm(0);                   check_all("R7");

    // short low pulse: 4 ticks
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (4 * BIT_CLKS) @(negedge clk);
    check_all("R3");
    send(8'hC3, 1'b0, 1'b0);  check_all("R3");

    rx_en = 0; @(negedge clk); check_all("R1");
    send(8'h99, 1'b0, 1'b1);  check_all("R1");
    rx_en = 1; @(negedge clk);
    ie_rx = 0; ie_err = 0; @(negedge clk); check_all("R11");
    ie_rx = 1; @(negedge clk); check_all("R11");
    clear(1, 1, 1, 1, 1);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] d;
      logic b9, st;
      d  = 8'($urandom);
      b9 = 1'($urandom);
      st = ($urandom % 8) != 0;
      mp_fmt = 1'($urandom);
      par_en = 1'($urandom);
      ie_rx  = 1'($urandom);
      ie_err = 1'($urandom);
      if (($urandom % 4) == 0) arm(1);
      if (($urandom % 2) == 0)
        clear(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      send(d, b9, st);
      check_all(mp_fmt ? "R9" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule